// File: doc/BRIEF.md
# DMA channel configuration write guard

This block guards the register window of one DMA channel. It watches a simple single-cycle register bus and, for every write that lands on one of the channel's external registers, raises a one-cycle write enable for that register. The registers that make up the channel's static setup can be write-protected: while a protect bit is set, writes to them complete on the bus but produce no enable. The registers that software needs at run time are never protected. These are the command register, the progress counters and the live address copies.

The protect bit can be set and cleared freely until a seal bit is written. The seal bit can only be set, and it stays set until reset. Once it is set, the protect bit keeps whatever value it had. Every access to the window also records who made it. The accessor's zone, link, route, CPU identifier, privilege identifier, privilege level and secure flag are held in two read-only attribute registers.

The owning channel keeps the contents of the external registers. It uses `wen_o` together with the bus data. Reads return data only for the four registers this block holds. The parent merges that data with its own.

Top module: `dma_cfg_guard`

## Requirements
- R1: After reset the protect bit, the seal bit and both attribute registers are 0, `wen_o` is 0 and `resp_valid_o` is 0.
- R2: With protection off, a write to word index k (byte offset 4*k, k from 0 to 24) raises only bit k of `wen_o`, and only during the request cycle.
- R3: While the protect bit is 1, writes to word indices 0 to 15 (the protected setup registers) raise no bit of `wen_o`.
- R4: Writes to word indices 16 to 24 (the command register, the counters and the live addresses) raise their enable whatever the protect bit holds.
- R5: The protect bit is bit 0 of offset 0x80. A write there takes effect for later accesses only while the seal bit is 0, and the bit reads back at the same position.
- R6: The seal bit is bit 0 of offset 0x84. Writing 1 sets it and writing 0 has no effect. Only reset clears it.
- R7: Every access at any offset, whether a read or a write, captures the accessor attributes. Offset 0x88 holds zone [3:0], link [7:4], route [11:8] and CPU id [15:12]. Offset 0x8C holds privilege id [7:0], privilege level [9:8] and secure [10]. All other bits of both registers are 0.
- R8: A read of an attribute register returns the attributes of the previous access, not those of the read itself.
- R9: Reads at any offset other than 0x80, 0x84, 0x88 and 0x8C return 0. Writes at offsets above 0x60 raise no enable.
- R10: Every request, including a blocked write, is answered by `resp_valid_o` in the following cycle, with read data in `rdata_o`. There is no error response.
- R11: Reads never raise any bit of `wen_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Byte offset within the channel window |
| wdata_i | input | DATA_W | Write data |
| acc_zone_i | input | 4 | Accessor zone |
| acc_link_i | input | 4 | Accessor link |
| acc_route_i | input | 4 | Accessor route identifier |
| acc_cpu_i | input | 4 | Accessor CPU identifier |
| acc_priv_id_i | input | 8 | Accessor privilege identifier |
| acc_priv_lvl_i | input | 2 | Accessor privilege level |
| acc_secure_i | input | 1 | Accessor secure flag |
| wen_o | output | NUM_PROT+NUM_OPEN | Per-register write enable, bit k for word index k |
| resp_valid_o | output | 1 | Response strobe, one cycle after each request |
| rdata_o | output | DATA_W | Read data, valid with resp_valid_o |

## Verification
The assertions assume the following about the inputs during a request cycle: `req_i`, `we_i`, `addr_i` and the attribute inputs carry known values, and there is at most one access per cycle. They do not assume anything about the low two address bits. The stimulus drives every input from a single task one clock after the edge, holds all inputs for exactly one cycle, and uses only word-aligned offsets. Attribute values are derived from a running sequence number, so consecutive accesses always differ.

// File: rtl/dma_cfg_guard_pkg.sv
package dma_cfg_guard_pkg;
  localparam int unsigned ZONE_W     = 4;
  localparam int unsigned LINK_W     = 4;
  localparam int unsigned ROUTE_W    = 4;
  localparam int unsigned CPU_W      = 4;
  localparam int unsigned PRIV_ID_W  = 8;
  localparam int unsigned PRIV_LVL_W = 2;

  // word indices of the registers held here
  localparam int unsigned LOCK_WORD   = 32;
  localparam int unsigned COMMIT_WORD = 33;
  localparam int unsigned ATTR_A_WORD = 34;
  localparam int unsigned ATTR_B_WORD = 35;

  typedef struct packed {
    logic [CPU_W-1:0]   cpu;
    logic [ROUTE_W-1:0] route;
    logic [LINK_W-1:0]  link;
    logic [ZONE_W-1:0]  zone;
  } attr_a_t;

  typedef struct packed {
    logic                  secure;
    logic [PRIV_LVL_W-1:0] lvl;
    logic [PRIV_ID_W-1:0]  id;
  } attr_b_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOCK,
    SEL_COMMIT,
    SEL_ATTR_A,
    SEL_ATTR_B
  } own_sel_e;
endpackage

// File: rtl/dma_cfg_guard_dec.sv
module dma_cfg_guard_dec
  import dma_cfg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned NUM_PROT = 16,
  parameter int unsigned NUM_OPEN = 9
) (
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [NUM_PROT+NUM_OPEN-1:0] ext_hit_o,
  output logic                         prot_hit_o,
  output own_sel_e                     own_sel_o
);
  localparam int unsigned NUM_EXT = NUM_PROT + NUM_OPEN;
  localparam int unsigned IDX_W   = ADDR_W - 2;

  logic [IDX_W-1:0] word;
  logic             unused_low;

  assign word       = addr_i[ADDR_W-1:2];
  assign unused_low = ^addr_i[1:0];

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_hit
    assign ext_hit_o[g] = (word == IDX_W'(g));
  end

  assign prot_hit_o = |ext_hit_o[NUM_PROT-1:0];

  always_comb begin
    own_sel_o = SEL_NONE;
    case (word)
      IDX_W'(LOCK_WORD):   own_sel_o = SEL_LOCK;
      IDX_W'(COMMIT_WORD): own_sel_o = SEL_COMMIT;
      IDX_W'(ATTR_A_WORD): own_sel_o = SEL_ATTR_A;
      IDX_W'(ATTR_B_WORD): own_sel_o = SEL_ATTR_B;
      default:             own_sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dma_cfg_guard_lock.sv
module dma_cfg_guard_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_wr_i,
  input  logic commit_wr_i,
  input  logic wbit_i,
  output logic lock_o,
  output logic commit_o
);
  logic lock_q, commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      if (lock_wr_i && !commit_q) lock_q <= wbit_i;
      if (commit_wr_i && wbit_i)  commit_q <= 1'b1;
    end
  end

  assign lock_o   = lock_q;
  assign commit_o = commit_q;

  assert_seal_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> commit_q);

  assert_sealed_lock_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> $stable(lock_q));

  assert_open_lock_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr_i && !commit_q) |=> (lock_q == $past(wbit_i)));
endmodule

// File: rtl/dma_cfg_guard_attr.sv
module dma_cfg_guard_attr
  import dma_cfg_guard_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    capture_i,
  input  attr_a_t attr_a_i,
  input  attr_b_t attr_b_i,
  output attr_a_t attr_a_o,
  output attr_b_t attr_b_o
);
  attr_a_t a_q;
  attr_b_t b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (capture_i) begin
      a_q <= attr_a_i;
      b_q <= attr_b_i;
    end
  end

  assign attr_a_o = a_q;
  assign attr_b_o = b_q;

  assert_attr_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (a_q == $past(attr_a_i)) && (b_q == $past(attr_b_i)));

  assert_attr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(a_q) && $stable(b_q));
endmodule

// File: rtl/dma_cfg_guard.sv
module dma_cfg_guard
  import dma_cfg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_PROT = 16,
  parameter int unsigned NUM_OPEN = 9
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [ZONE_W-1:0]            acc_zone_i,
  input  logic [LINK_W-1:0]            acc_link_i,
  input  logic [ROUTE_W-1:0]           acc_route_i,
  input  logic [CPU_W-1:0]             acc_cpu_i,
  input  logic [PRIV_ID_W-1:0]         acc_priv_id_i,
  input  logic [PRIV_LVL_W-1:0]        acc_priv_lvl_i,
  input  logic                         acc_secure_i,
  output logic [NUM_PROT+NUM_OPEN-1:0] wen_o,
  output logic                         resp_valid_o,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int unsigned NUM_EXT = NUM_PROT + NUM_OPEN;
  localparam logic [NUM_EXT-1:0] PROT_MASK = NUM_EXT'((64'(1) << NUM_PROT) - 64'(1));

  logic [NUM_EXT-1:0] ext_hit;
  logic               prot_hit;
  own_sel_e           own_sel;
  logic               lock_q, commit_q;
  attr_a_t            attr_a_in, attr_a_q;
  attr_b_t            attr_b_in, attr_b_q;
  logic [DATA_W-1:0]  rd_d;
  logic               resp_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  dma_cfg_guard_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_PROT(NUM_PROT),
    .NUM_OPEN(NUM_OPEN)
  ) u_dec (
    .addr_i    (addr_i),
    .ext_hit_o (ext_hit),
    .prot_hit_o(prot_hit),
    .own_sel_o (own_sel)
  );

  dma_cfg_guard_lock u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_wr_i  (req_i && we_i && (own_sel == SEL_LOCK)),
    .commit_wr_i(req_i && we_i && (own_sel == SEL_COMMIT)),
    .wbit_i     (wdata_i[0]),
    .lock_o     (lock_q),
    .commit_o   (commit_q)
  );

  assign attr_a_in = '{cpu: acc_cpu_i, route: acc_route_i, link: acc_link_i, zone: acc_zone_i};
  assign attr_b_in = '{secure: acc_secure_i, lvl: acc_priv_lvl_i, id: acc_priv_id_i};

  dma_cfg_guard_attr u_attr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(req_i),
    .attr_a_i (attr_a_in),
    .attr_b_i (attr_b_in),
    .attr_a_o (attr_a_q),
    .attr_b_o (attr_b_q)
  );

  // blocked writes still complete; only the enable is withheld
  assign wen_o = (req_i && we_i && !(prot_hit && lock_q)) ? ext_hit : '0;

  always_comb begin
    case (own_sel)
      SEL_LOCK:   rd_d = DATA_W'(lock_q);
      SEL_COMMIT: rd_d = DATA_W'(commit_q);
      SEL_ATTR_A: rd_d = DATA_W'(attr_a_q);
      SEL_ATTR_B: rd_d = DATA_W'(attr_b_q);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q  <= req_i;
      rdata_q <= (req_i && !we_i) ? rd_d : '0;
    end
  end

  assign resp_valid_o = resp_q;
  assign rdata_o      = rdata_q;

  assert_single_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wen_o));

  assert_locked_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && lock_q) |-> ((wen_o & PROT_MASK) == '0));

  assert_open_unaffected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && lock_q && ((ext_hit & ~PROT_MASK) != '0)) |-> (wen_o != '0));

  assert_reserved_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (own_sel == SEL_NONE)) |=> (rdata_o == '0));

  assert_resp_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> resp_valid_o);

  assert_no_spurious_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !resp_valid_o);

  assert_read_no_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |-> (wen_o == '0));
endmodule

// File: tb/dma_cfg_guard_tb.sv
module dma_cfg_guard_tb;
  localparam int NEXT = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  zone = '0, link = '0, route = '0, cpu = '0;
  logic [7:0]  pid = '0;
  logic [1:0]  plvl = '0;
  logic        sec = 1'b0;
  logic [NEXT-1:0] wen;
  logic        resp_valid;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  int seq = 1;

  logic        m_lock = 1'b0, m_commit = 1'b0;
  logic [15:0] m_a = '0;
  logic [10:0] m_b = '0;

  logic [31:0]     exp_rd_q[$];
  logic [NEXT-1:0] exp_wen_q[$];
  string           exp_tag_q[$];

  logic            req_prev = 1'b0;
  logic [NEXT-1:0] wen_prev = '0;

  always #10 clk = ~clk;

  dma_cfg_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .acc_zone_i(zone), .acc_link_i(link), .acc_route_i(route), .acc_cpu_i(cpu),
    .acc_priv_id_i(pid), .acc_priv_lvl_i(plvl), .acc_secure_i(sec),
    .wen_o(wen), .resp_valid_o(resp_valid), .rdata_o(rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: response strobe, read data and enables against the scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      req_prev = 1'b0;
      wen_prev = '0;
    end else begin
      check(resp_valid === req_prev, "R10 resp strobe", 32'(resp_valid), 32'(req_prev));
      if (resp_valid) begin
        if (exp_rd_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", 32'd1, 32'd0);
        end else begin
          logic [31:0] er;
          logic [NEXT-1:0] ew;
          string t;
          er = exp_rd_q.pop_front();
          ew = exp_wen_q.pop_front();
          t  = exp_tag_q.pop_front();
          check(rdata === er, {t, " rdata"}, rdata, er);
          check(wen_prev === ew, {t, " wen"}, 32'(wen_prev), 32'(ew));
        end
      end
      req_prev = req;
      wen_prev = wen;
    end
  end

  task automatic access(input logic w, input logic [8:0] a, input logic [31:0] d, input string tag);
    int k;
    logic [31:0] er;
    logic [NEXT-1:0] ew;
    logic [3:0] s;
    @(posedge clk);
    #1;
    s = seq[3:0];
    req = 1'b1; we = w; addr = a; wdata = d;
    zone = s; link = s + 4'd1; route = ~s; cpu = s ^ 4'hA;
    pid = 8'(seq * 3); plvl = seq[1:0]; sec = seq[0];
    k = int'(a[8:2]);
    ew = '0;
    if (w && k < NEXT && !(k < 16 && m_lock)) ew = NEXT'(1) << k;
    er = '0;
    if (!w) begin
      case (k)
        32: er = 32'(m_lock);
        33: er = 32'(m_commit);
        34: er = 32'(m_a);
        35: er = 32'(m_b);
        default: er = '0;
      endcase
    end
    exp_rd_q.push_back(er);
    exp_wen_q.push_back(ew);
    exp_tag_q.push_back(tag);
    if (w && k == 32 && !m_commit) m_lock = d[0];
    if (w && k == 33 && d[0]) m_commit = 1'b1;
    m_a = {cpu, route, link, zone};
    m_b = {sec, plvl, pid};
    seq++;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    repeat (2) @(negedge clk);
    #1;
    rst_n = 1'b0;
    m_lock = 1'b0; m_commit = 1'b0; m_a = '0; m_b = '0;
    #5;
    check(wen === '0, "R1 wen in reset", 32'(wen), 32'd0);
    check(resp_valid === 1'b0, "R1 resp in reset", 32'(resp_valid), 32'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values read back
    access(1'b0, 9'h080, 0, "R1 lock after reset");
    access(1'b0, 9'h084, 0, "R1 seal after reset");
    access(1'b0, 9'h088, 0, "R8 attr A of previous access");
    access(1'b0, 9'h08C, 0, "R7 attr B");
    // R2 every external register unprotected, back to back
    for (int k = 0; k < NEXT; k++) access(1'b1, 9'(k * 4), 32'hFFFF_0000 + k, "R2 unlocked write");
    // R11 reads of external registers
    access(1'b0, 9'h000, 0, "R11 read protected");
    access(1'b0, 9'h040, 0, "R11 read command");
    // R5 set protect
    access(1'b1, 9'h080, 32'h1, "R5 set protect");
    access(1'b0, 9'h080, 0, "R5 protect reads 1");
    for (int k = 0; k < NEXT; k++) access(1'b1, 9'(k * 4), 32'h5A5A_5A5A, k < 16 ? "R3 locked write" : "R4 open write");
    idle();
    // R9 reserved offsets
    access(1'b1, 9'h064, 32'h1, "R9 reserved write");
    access(1'b0, 9'h064, 0, "R9 reserved read");
    access(1'b1, 9'h090, 32'h1, "R9 reserved write high");
    access(1'b0, 9'h1FC, 0, "R9 reserved read top");
    // R5 clear protect
    access(1'b1, 9'h080, 32'h0, "R5 clear protect");
    access(1'b1, 9'h014, 32'h7, "R2 write after unlock");
    // R6 writing 0 to seal
    access(1'b1, 9'h084, 32'h0, "R6 seal write 0");
    access(1'b0, 9'h084, 0, "R6 seal still 0");
    access(1'b1, 9'h080, 32'h1, "R5 protect again");
    access(1'b1, 9'h084, 32'hFFFF_FFFF, "R6 seal set");
    access(1'b0, 9'h084, 0, "R6 seal reads 1");
    access(1'b1, 9'h080, 32'h0, "R5 sealed protect write");
    access(1'b0, 9'h080, 0, "R5 protect frozen at 1");
    access(1'b1, 9'h03C, 32'h1, "R3 sealed protected write");
    access(1'b1, 9'h060, 32'h1, "R4 sealed open write");
    access(1'b1, 9'h084, 32'h0, "R6 seal write 0 when set");
    // R7 R8 attributes across a write then reads
    access(1'b1, 9'h100, 32'h0, "R7 write at reserved offset");
    access(1'b0, 9'h088, 0, "R7 attr A after write");
    access(1'b0, 9'h08C, 0, "R8 attr B after read");
    access(1'b0, 9'h088, 0, "R8 attr A after read");
    idle();
    // R6 only reset clears the seal
    do_reset();
    access(1'b0, 9'h084, 0, "R6 seal cleared by reset");
    access(1'b0, 9'h080, 0, "R1 protect cleared by reset");
    access(1'b0, 9'h088, 0, "R1 attr A after reset");
    access(1'b1, 9'h000, 32'h1, "R2 write after reset");
    idle();
    repeat (3) @(posedge clk);
    check(exp_rd_q.size() == 0, "R10 all responses seen", 32'(exp_rd_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule